// File: doc/BRIEF.md
# Keyed Mode Register Guard

This block protects one mode-control register from stray stores. It sits on a simple memory-mapped bus with an address, a write strobe, write data, a read strobe and read data. Software first writes the unlock key 0xA5 to a key register. It then makes three stores to the mode register: the intended value, the bitwise inverse of that value, and the intended value once more. Only the last of these stores changes the register. Any departure from this sequence throws the sequence away and latches a sticky fault flag in a status register.

The mode register holds one writable mode bit at bit 0, where 0 is normal operation and 1 is self-programming. It also holds a read-only five-bit field at bits 6:2, which is captured from a protect-byte input while reset is asserted.

Top module: `keyed_mode_guard`

## Requirements
- R1: Register addresses are: key register at offset 0, mode register at offset 1, status register at offset 2. Out of reset, the mode bit (bit 0 of the mode register) reads 0, the status register reads 0 and the sequencer is idle.
- R2: Bits 6:2 of the mode register read the protect-byte input captured during reset. Bits 1 and 7 read 0. Stores to the mode register never change bits 6:2.
- R3: A store of 0xA5 to the key register arms the sequence. The next three stores to the mode register, carrying value V, then ~V, then V again, update the mode bit to V[0] on the third store only. The first two stores leave the register unchanged.
- R4: One key permits one committed update. After a commit the sequencer is idle again, and a further store to the mode register without a new key is illegal.
- R5: Each of the following is an illegal store. The sequencer goes to idle, status bit 0 is set, and the mode bit is unchanged:
  - a store to the mode register with no key;
  - a second store whose bit 0 is not the inverse of the first store's bit 0;
  - a third store whose bit 0 differs from the first store's bit 0.
  Only bit 0, the writable bit, takes part in these comparisons.
- R6: A store of any value other than 0xA5 to the key register returns the sequencer to idle without setting the error flag.
- R7: Stores to addresses other than the key and mode registers neither advance nor abort the sequence.
- R8: Status bit 0 stays set until software stores a 1 to status bit 0, or until reset. Storing 0 to that bit leaves it unchanged. If an illegal store and a clearing store fall in the same cycle, the flag ends up set.
- R9: The key register reads back the last value stored to it. Reads have no side effects. Read data is combinational from the address when the read strobe is high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prot_in | input | 5 | Protect byte, captured while in reset |
| addr | input | 2 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data |
| mode_bit | output | 1 | Current mode bit |

## Verification
The bus performs one store per cycle, so an illegal store and a clear of the fault flag cannot arrive on the same edge from the bus. The only concurrency that can occur is a fault being set while the flag is already set, which a set-priority update absorbs. The bench provokes this by leaving the flag set, committing further illegal stores and then clearing it, and checks that a single clear store returns status to 0. Random sequences mix key, mode, status and unused-address stores. Every store is compared against a bench model of the sequencer, and all registers are read back after each step.

// File: rtl/keyed_mode_guard.sv
module keyed_mode_guard #(
  parameter int AW = 2,
  parameter int DW = 8,
  parameter int PW = 5,
  parameter logic [DW-1:0] KEY = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] prot_in,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          mode_bit
);
  localparam logic [AW-1:0] A_KEY  = AW'(0);
  localparam logic [AW-1:0] A_MODE = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);

  typedef enum logic [1:0] {IDLE, ARMED, GOT1, GOT2} st_t;
  st_t st;
  logic [DW-1:0] key_q;
  logic [PW-1:0] prot_q;
  logic first_q, err_q;

  wire wk = wr_en && addr == A_KEY;
  wire wm = wr_en && addr == A_MODE;
  wire ws = wr_en && addr == A_STAT;
  wire b  = wr_data[0];

  logic bad, commit;
  st_t  st_n;
  always_comb begin
    bad = 1'b0; commit = 1'b0; st_n = st;
    if (wk) st_n = (wr_data == KEY) ? ARMED : IDLE;
    else if (wm) begin
      case (st)
        IDLE:  bad = 1'b1;
        ARMED: st_n = GOT1;
        GOT1:  if (b == ~first_q) st_n = GOT2; else bad = 1'b1;
        GOT2:  if (b == first_q) commit = 1'b1; else bad = 1'b1;
        default: bad = 1'b1;
      endcase
      if (bad || commit) st_n = IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; key_q <= '0; first_q <= 1'b0; err_q <= 1'b0;
      mode_bit <= 1'b0; prot_q <= prot_in;
    end else begin
      st <= st_n;
      if (wk) key_q <= wr_data;
      if (wm && st == ARMED) first_q <= b;
      if (commit) mode_bit <= b;
      if (bad) err_q <= 1'b1;
      else if (ws && b) err_q <= 1'b0;
    end
  end

  wire [DW-1:0] mode_rd = {1'b0, prot_q, 1'b0, mode_bit};
  always_comb begin
    rd_data = '0;
    if (rd_en)
      case (addr)
        A_KEY:  rd_data = key_q;
        A_MODE: rd_data = mode_rd;
        A_STAT: rd_data = {{(DW-1){1'b0}}, err_q};
        default: rd_data = '0;
      endcase
  end

  // R3
  mode_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wm && st == GOT2) |=> $stable(mode_bit));
  // R5
  err_on_unkeyed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wm && st == IDLE) |=> err_q && st == IDLE);
  // R2
  prot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 $stable(prot_q));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(ws && b)) |=> err_q);
  // R6
  badkey_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wk && wr_data != KEY) |=> st == IDLE && $stable(err_q));
endmodule

// File: tb/tb_keyed_mode_guard.sv
module tb_keyed_mode_guard;
  logic clk = 0, rst_n = 0;
  logic [4:0] prot_in = 5'b10110;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic mode_bit;
  int checks = 0, fails = 0;

  keyed_mode_guard dut (.clk(clk), .rst_n(rst_n), .prot_in(prot_in), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .mode_bit(mode_bit));

  always #5 clk = ~clk;

  int m_st = 0; logic m_first = 0, m_mode = 0, m_err = 0; logic [7:0] m_key = 0;

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return m_key;
      2'd1: return {1'b0, prot_in, 1'b0, m_mode};
      2'd2: return {7'b0, m_err};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model(input logic [1:0] a, input logic [7:0] d);
    logic bad = 0;
    if (a == 0) begin m_key = d; m_st = (d == 8'hA5) ? 1 : 0; end
    else if (a == 1) begin
      case (m_st)
        0: bad = 1;
        1: begin m_first = d[0]; m_st = 2; end
        2: if (d[0] == ~m_first) m_st = 3; else bad = 1;
        default: if (d[0] == m_first) begin m_mode = d[0]; m_st = 0; end else bad = 1;
      endcase
      if (bad) begin m_err = 1; m_st = 0; end
    end else if (a == 2 && d[0]) m_err = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    model(a, d);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic rd(input logic [1:0] a, input string req);
    @(negedge clk); addr = a; rd_en = 1; #1;
    chk(req, rd_data, exp_read(a));
    rd_en = 0;
  endtask

  task automatic all_rd(input string req);
    for (int i = 0; i < 4; i++) rd(2'(i), req);
    chk({req, " mode_bit"}, {7'b0, mode_bit}, {7'b0, m_mode});
  endtask

  initial begin
    #2000000; fails++; $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks + 1); $finish;
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    repeat (3) @(negedge clk); rst_n = 1;
    // R1 R2 reset state
    all_rd("R1");
    rd(1, "R2");
    // R3 proper commit, intermediate stores leave register alone
    wr(0, 8'hA5); wr(1, 8'h01); all_rd("R3");
    wr(1, 8'hFE); all_rd("R3"); wr(1, 8'hFD); all_rd("R3");
    chk("R3 commit", {7'b0, mode_bit}, 8'h01);
    // R2 read-only field untouched
    rd(1, "R2");
    // R4 no key -> illegal
    wr(1, 8'h00); all_rd("R4");
    chk("R4 err", {7'b0, m_err}, 8'h01);
    // R8 clear with 0 keeps, with 1 clears
    wr(2, 8'h00); all_rd("R8");
    wr(0, 8'hA5); wr(1, 8'h00); wr(1, 8'h00); all_rd("R5"); // bad inverse while err set
    wr(2, 8'h01); all_rd("R8");
    // R5 bad third
    wr(0, 8'hA5); wr(1, 8'h00); wr(1, 8'h01); wr(1, 8'h01); all_rd("R5");
    wr(2, 8'h01);
    // R6 non-key aborts silently
    wr(0, 8'hA5); wr(1, 8'h00); wr(0, 8'h5A); all_rd("R6");
    wr(1, 8'h00); all_rd("R6");
    wr(2, 8'h01);
    // R7 unused/status writes do not disturb
    wr(0, 8'hA5); wr(3, 8'hFF); wr(1, 8'h00); wr(2, 8'h00); wr(1, 8'h01);
    wr(3, 8'h12); wr(1, 8'h00); all_rd("R7");
    chk("R7 commit", {7'b0, mode_bit}, 8'h00);
    // R9 key readback
    wr(0, 8'h3C); rd(0, "R9"); rd(0, "R9");
    @(negedge clk); addr = 0; rd_en = 0; #1; chk("R9 idle read", rd_data, 8'h00);
    // random
    for (int n = 0; n < 400; n++) begin
      logic [1:0] a; logic [7:0] d; int r;
      r = $urandom_range(0, 9);
      a = (r < 3) ? 2'd0 : (r < 8) ? 2'd1 : 2'(r - 6);
      d = $urandom;
      if (a == 0 && $urandom_range(0, 1)) d = 8'hA5;
      if (a == 1 && m_st == 2 && $urandom_range(0, 3) != 0) d[0] = ~m_first;
      if (a == 1 && m_st == 3 && $urandom_range(0, 3) != 0) d[0] = m_first;
      wr(a, d);
      all_rd("R5");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule